// File: doc/BRIEF.md
# Triggered Parallel Input Capture Port

This block is one input port of a digital acquisition module. A configuration field picks one of several asynchronous backplane trigger lines. After synchronization, an edge on that line starts a high pulse of fixed width on the clock output toward the device under test. When that pulse ends, the port captures the parallel input bus.

The capture marks the data as pending and asserts an interrupt. The host then drains the captured word through a read strobe, 16 bits at a time, least significant word first. Each word takes two strobes: one that presents it and one that steps past it. A capture that lands on unread data replaces that data and sets a sticky overrun flag.

Configuration is written through a small register port:
- Address 0 holds the control bits: bit 0 trigger enable, bit 1 invert, bit 2 clock drive, bit 3 interrupt active-low.
- Address 1 holds the trigger select.
- Address 2 is the acknowledge register: bit 0 clears the interrupt, bit 1 clears the overrun flag.

Top module: `trig_capture_port`

## Requirements
- R1: While control bit 0 (trigger enable) is 0, trigger activity produces no output pulse, no capture and no interrupt.
- R2: Only the trigger line whose index equals the select register (address 1) is used. Edges on every other line are ignored.
- R3: With invert clear, a rising edge on the selected line produces a high pulse on `uut_clk_o` exactly PULSE_W clock cycles long, starting 3 clock edges after the line changes. Edges that arrive while a pulse is running are ignored.
- R4: The data bus is sampled on the clock edge at which the output pulse falls. A value changed during the pulse is the one that is captured.
- R5: With control bit 1 (invert) set, a falling edge of the selected line is the event, and a rising edge does nothing.
- R6: `uut_clk_oe_o` equals control bit 2. While that bit is 0, `uut_clk_o` stays low, but capture still takes place.
- R7: A capture sets the interrupt request. `irq_o` equals pending XOR control bit 3, so it is active high when the bit is 0 and active low when it is 1.
- R8: Read strobes alternate between two phases. An odd strobe loads the current 16-bit word onto `rd_data_o` one edge later. An even strobe advances to the next word. Word 0 is data bits 15:0.
- R9: The strobe that advances past the last word clears the interrupt. Writing 1 to bit 0 at address 2 also clears it, and leaves the overrun flag unchanged.
- R10: A capture while data is still pending overwrites the data and sets `ovr_o`. `ovr_o` stays set through reads, and only writing 1 to bit 1 at address 2 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register address |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| trig_i | input | NUM_TRIG | Asynchronous trigger lines |
| uut_clk_o | output | 1 | Clock pulse toward the device under test |
| uut_clk_oe_o | output | 1 | Drive enable for the clock line |
| data_i | input | DATA_W | Parallel input data |
| irq_o | output | 1 | Interrupt request, polarity from configuration |
| ovr_o | output | 1 | Sticky overrun flag |
| rd_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Read data word |

## Verification
A trigger change reaches the edge detector after two synchronizer edges. The pulse register loads on the third edge, the pulse lasts PULSE_W cycles, and capture and the interrupt take effect on the edge where the pulse falls. The bench therefore waits a fixed 12-cycle window after each trigger change and counts high pulse cycles at falling clock edges within it. It swaps the data bus at the first falling edge that sees the pulse high, which shows that the sampling happens at the end of the pulse. Read data is registered, so each strobe is held for one cycle and the result is sampled at the next falling edge.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SEL  = 2'd1;
  localparam logic [1:0] ADDR_ACK  = 2'd2;

  typedef struct packed {
    logic irq_low;
    logic drive;
    logic inv;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tcp_trig_sync.sv
module tcp_trig_sync #(
  parameter int NUM_TRIG = 8,
  parameter int SEL_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                en_i,
  input  logic                inv_i,
  output logic                evt_o
);
  logic [NUM_TRIG-1:0] s1_q, s2_q;
  logic lvl, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= trig_i;
      s2_q   <= s1_q;
      prev_q <= lvl;
    end
  end

  always_comb begin
    lvl = 1'b0;
    for (int k = 0; k < NUM_TRIG; k++)
      if (sel_i == SEL_W'(k)) lvl = s2_q[k];
  end

  // prev tracks the ungated level so enabling never fakes an edge from history
  assign evt_o = en_i & (inv_i ? (prev_q & ~lvl) : (~prev_q & lvl));
endmodule

// File: rtl/tcp_pulse_gen.sv
module tcp_pulse_gen #(
  parameter int PULSE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic pulse_o,
  output logic cap_o
);
  localparam int CW = $clog2(PULSE_W + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (cnt_q == '0 && evt_i)   cnt_q <= CW'(PULSE_W);
    else if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);
  assign cap_o   = (cnt_q == CW'(1));

  assert_cap_at_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> !pulse_o);
  assert_pulse_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && !cap_o) |=> pulse_o);
  assert_pulse_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(evt_i));
endmodule

// File: rtl/tcp_capture_store.sv
module tcp_capture_store #(
  parameter int DATA_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_i,
  input  logic              ack_irq_i,
  input  logic              ack_ovr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              pend_o,
  output logic              ovr_o
);
  localparam int NWORD = DATA_W / WORD_W;
  localparam int IDX_W = (NWORD > 1) ? $clog2(NWORD) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORD - 1);

  logic [DATA_W-1:0] data_q;
  logic [WORD_W-1:0] words [NWORD];
  logic [IDX_W-1:0]  idx_q;
  logic              phase_q;

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    assign words[g] = data_q[g*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q    <= '0;
      idx_q     <= '0;
      phase_q   <= 1'b0;
      pend_o    <= 1'b0;
      rd_data_o <= '0;
    end else if (cap_i) begin
      data_q  <= data_i;
      idx_q   <= '0;
      phase_q <= 1'b0;
      pend_o  <= 1'b1;
    end else begin
      if (ack_irq_i) pend_o <= 1'b0;
      if (rd_i) begin
        if (!phase_q) begin
          rd_data_o <= words[idx_q];
          phase_q   <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          if (idx_q == LAST) begin
            idx_q  <= '0;
            pend_o <= 1'b0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ovr_o <= 1'b0;
    else if (cap_i && pend_o)  ovr_o <= 1'b1;
    else if (ack_ovr_i)        ovr_o <= 1'b0;
  end

  assert_irq_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> pend_o);
  assert_ovr_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && pend_o) |=> ovr_o);
  assert_ovr_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ack_ovr_i) |=> ovr_o);
  assert_phase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !phase_q && !cap_i) |=> (phase_q && $stable(idx_q)));
  assert_drain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && phase_q && idx_q == LAST && !cap_i) |=> !pend_o);
endmodule

// File: rtl/trig_capture_port.sv
module trig_capture_port #(
  parameter int NUM_TRIG = 8,
  parameter int DATA_W   = 32,
  parameter int PULSE_W  = 4,
  parameter int CFG_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_addr_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  input  logic [NUM_TRIG-1:0] trig_i,
  output logic                uut_clk_o,
  output logic                uut_clk_oe_o,
  input  logic [DATA_W-1:0]   data_i,
  output logic                irq_o,
  output logic                ovr_o,
  input  logic                rd_i,
  output logic [15:0]         rd_data_o
);
  import tcp_pkg::*;

  ctrl_t            ctrl_q;
  logic [CFG_W-1:0] sel_q;
  logic evt, pulse, cap, pend, ack_irq, ack_ovr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sel_q  <= '0;
    end else if (cfg_we_i) begin
      if (cfg_addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(cfg_wdata_i[3:0]);
      if (cfg_addr_i == ADDR_SEL)  sel_q  <= cfg_wdata_i;
    end
  end

  assign ack_irq = cfg_we_i && cfg_addr_i == ADDR_ACK && cfg_wdata_i[0];
  assign ack_ovr = cfg_we_i && cfg_addr_i == ADDR_ACK && cfg_wdata_i[1];

  tcp_trig_sync #(.NUM_TRIG(NUM_TRIG), .SEL_W(CFG_W)) u_sync (
    .clk_i, .rst_ni, .trig_i, .sel_i(sel_q), .en_i(ctrl_q.en),
    .inv_i(ctrl_q.inv), .evt_o(evt));

  tcp_pulse_gen #(.PULSE_W(PULSE_W)) u_pulse (
    .clk_i, .rst_ni, .evt_i(evt), .pulse_o(pulse), .cap_o(cap));

  tcp_capture_store #(.DATA_W(DATA_W), .WORD_W(16)) u_store (
    .clk_i, .rst_ni, .cap_i(cap), .data_i, .rd_i, .ack_irq_i(ack_irq),
    .ack_ovr_i(ack_ovr), .rd_data_o, .pend_o(pend), .ovr_o);

  assign uut_clk_o    = pulse & ctrl_q.drive;
  assign uut_clk_oe_o = ctrl_q.drive;
  assign irq_o        = pend ^ ctrl_q.irq_low;

  assert_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse) |-> $past(ctrl_q.en));
  assert_drive_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uut_clk_oe_o |-> !uut_clk_o);
endmodule

// File: tb/trig_capture_port_test.sv
module trig_capture_port_test;
  localparam int NT = 8, DW = 32, PW = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [3:0] cfg_wdata = 0;
  logic [NT-1:0] trig = 0;
  logic [DW-1:0] data = 0;
  logic rd = 0;
  logic uut_clk, uut_clk_oe, irq, ovr;
  logic [15:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trig_capture_port #(.NUM_TRIG(NT), .DATA_W(DW), .PULSE_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .trig_i(trig), .uut_clk_o(uut_clk),
    .uut_clk_oe_o(uut_clk_oe), .data_i(data), .irq_o(irq), .ovr_o(ovr),
    .rd_i(rd), .rd_data_o(rd_data));

  function automatic logic [15:0] exp_word(logic [DW-1:0] d, int i);
    return d[16*i +: 16];
  endfunction

  function automatic logic exp_irq(logic pending, logic low);
    return pending ^ low;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] a, logic [3:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic strobe();
    @(negedge clk); rd = 1;
    @(negedge clk); rd = 0;
  endtask

  // raise then lower one line; swap data when the pulse is first seen high
  task automatic fire(int line, logic [DW-1:0] d0, logic [DW-1:0] d1,
                      output int hi_n, output int lo_n);
    bit swapped = 0;
    hi_n = 0; lo_n = 0;
    @(negedge clk); data = d0; trig[line] = 1;
    for (int ph = 0; ph < 2; ph++) begin
      repeat (12) begin
        @(negedge clk);
        if (uut_clk) begin
          if (ph == 0) hi_n++; else lo_n++;
          if (!swapped) begin data = d1; swapped = 1; end
        end
      end
      trig[line] = 0;
    end
  endtask

  task automatic drain(logic [DW-1:0] exp, logic low, string req);
    for (int i = 0; i < DW/16; i++) begin
      strobe();
      chk(rd_data == exp_word(exp, i), req, rd_data, exp_word(exp, i));
      strobe();
    end
    chk(irq == exp_irq(0, low), "R9 irq cleared after last word", irq, exp_irq(0, low));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, lo;
    logic [DW-1:0] a, b;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!irq && !uut_clk && !uut_clk_oe && !ovr && rd_data == 0, "reset", {irq, uut_clk, uut_clk_oe, ovr}, 0);

    // R1: disabled, drive on
    cfg(2'd0, 4'b0100);
    chk(uut_clk_oe == 1, "R6 oe follows drive", uut_clk_oe, 1);
    fire(0, 32'h1111_2222, 32'h1111_2222, hi, lo);
    chk(hi + lo == 0 && irq == 0, "R1 disabled no pulse/irq", hi + lo, 0);

    // R3/R4: enable, rising edge, data swapped during pulse
    cfg(2'd0, 4'b0101);
    fire(0, 32'hAAAA_5555, 32'hCAFE_BEEF, hi, lo);
    chk(hi == PW && lo == 0, "R3 pulse width", hi, PW);
    chk(irq == 1, "R7 irq active high", irq, 1);
    drain(32'hCAFE_BEEF, 0, "R4/R8 word");

    // R2: select line 3, fire line 5 then line 3
    cfg(2'd1, 4'd3);
    fire(5, 32'h0, 32'h0, hi, lo);
    chk(hi + lo == 0 && irq == 0, "R2 unselected ignored", hi + lo, 0);
    fire(3, 32'h1234_5678, 32'h8765_4321, hi, lo);
    chk(hi == PW && irq == 1, "R2 selected line captures", hi, PW);
    drain(32'h8765_4321, 0, "R2 word");

    // R5: invert, falling edge is the event
    cfg(2'd0, 4'b0111);
    fire(3, 32'h0F0F_0F0F, 32'hF0F0_1357, hi, lo);
    chk(hi == 0 && lo == PW, "R5 falling edge event", {hi[15:0], lo[15:0]}, PW);
    drain(32'hF0F0_1357, 0, "R5 word");

    // R7: active-low interrupt, R9 ack
    cfg(2'd0, 4'b1101);
    chk(irq == 1, "R7 idle active-low", irq, 1);
    fire(3, 32'h5A5A_A5A5, 32'h6B6B_B6B6, hi, lo);
    chk(irq == 0, "R7 asserted active-low", irq, 0);
    cfg(2'd2, 4'b0001);
    chk(irq == 1 && ovr == 0, "R9 ack clears irq", irq, 1);

    // R10: capture while pending
    cfg(2'd0, 4'b0101);
    fire(3, 32'h1, 32'h2, hi, lo);
    chk(ovr == 0, "R10 no overrun after ack", ovr, 0);
    fire(3, 32'h3, 32'hDEAD_0004, hi, lo);
    chk(ovr == 1, "R10 overrun set", ovr, 1);
    drain(32'hDEAD_0004, 0, "R10 overwritten word");
    chk(ovr == 1, "R10 sticky after reads", ovr, 1);
    cfg(2'd2, 4'b0001);
    chk(ovr == 1, "R9 irq ack keeps overrun", ovr, 1);
    cfg(2'd2, 4'b0010);
    chk(ovr == 0, "R10 ack clears overrun", ovr, 0);

    // R6: drive off, capture still happens
    cfg(2'd0, 4'b0001);
    chk(uut_clk_oe == 0, "R6 oe low", uut_clk_oe, 0);
    fire(3, 32'h7777_9999, 32'h7777_9999, hi, lo);
    chk(hi + lo == 0 && irq == 1, "R6 no pulse but capture", hi + lo, 0);
    drain(32'h7777_9999, 0, "R6 word");

    // random
    for (int n = 0; n < 24; n++) begin
      int line = $urandom_range(NT-1, 0);
      logic inv = 1'($urandom_range(1, 0));
      a = $urandom; b = $urandom;
      cfg(2'd1, 4'(line));
      cfg(2'd0, {2'b01, inv, 1'b1});
      fire(line, a, b, hi, lo);
      chk((inv ? lo : hi) == PW, "R3/R5 random pulse", inv ? lo : hi, PW);
      chk(irq == 1, "R7 random irq", irq, 1);
      drain(b, 0, "R8 random word");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule